// File: doc/BRIEF.md
# Hot Swap Sequencing Controller

This block sequences the switch-on of a board power path that is plugged into a live supply. It watches a supply-good flag, a filtered enable pin and a software-off bit, and it drives a gate-enable output for an external power switch. Analog timing is replaced by one saturating up/down counter that ramps between a low and a high threshold. Each phase uses its own step size: a slow rise for the insertion delay, a steep rise while an overcurrent is timed, a fast discharge, and the slowest fall for the retry cool-down.

Two comparator flags come from the sense path. The fault-timing flag is raised when the load current is above the level at which overcurrent is timed. The fast-trip flag marks a short circuit. If the counter reaches the high threshold while the fault-timing flag is still high, the gate is forced off. A strap input then selects what happens next. In retry mode the counter cools down slowly and the switch-on is attempted again. In latch mode the gate stays off until the enable is released and applied again. A fast trip strobes the gate pull-down in the same cycle, without waiting for the counter.

Top module: `hsw_seq`

## Requirements
- R1: After reset, and in any cycle after supply_ok was sampled low, gate_en, gate_pd, fail_pulse and oc_off are all 0.
- R2: When supply_ok is sampled high after being low, the initial cycle runs and the gate turns on. With the enable active, gate_en rises exactly 1 + ceil(THR_HI/RATE_INIT) + 1 + ceil((THR_HI-THR_LO)/RATE_DISCH) + 2 clock edges after the first edge that samples supply_ok high. This count assumes the counter starts at 0.
- R3: gate_en rises only from the idle state and only while the filtered enable is active. If the enable becomes active after the initial cycle has finished, gate_en rises FILT_LEN+1 edges later.
- R4: A fault-timing burst that ends before the counter reaches THR_HI leaves gate_en at 1 and produces no fail_pulse.
- R5: A fault-timing flag held high from a counter value of 0 turns gate_en off after ceil(THR_HI/RATE_FAULT)+1 edges. In that same cycle fail_pulse is high for exactly one cycle.
- R6: With retry_mode=0, the gate stays off after a fault and oc_off stays 1 for as long as the enable remains active. Releasing and then reapplying the enable turns the gate on again.
- R7: With retry_mode=1, gate_en returns to 1 ceil((THR_HI-THR_LO)/RATE_COOL)+2 edges after the fault turned it off. oc_off is 1 during that cool-down.
- R8: gate_pd is 1 in the same cycle that fast_trip is 1 while gate_en is 1. A fast trip does not change gate_en.
- R9: sw_off turns gate_en off at the next edge, and clearing it turns the gate back on one edge later. Releasing the enable turns gate_en off FILT_LEN+1 edges later.
- R10: An enable glitch that lasts fewer than FILT_LEN cycles has no effect on gate_en.
- R11: The parameter EN_ACT_HIGH sets the enable polarity. With EN_ACT_HIGH=0, a low level on en_pin is active.
- R12: supply_ok sampled low while the gate is on turns gate_en off at the next edge. The following power-up repeats the full R2 sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above undervoltage lockout |
| en_pin | input | 1 | Enable pin, polarity set by EN_ACT_HIGH |
| sw_off | input | 1 | Software request to keep the gate off |
| oc_flag | input | 1 | Sense level above the fault-timing threshold |
| fast_trip | input | 1 | Sense level above the fast-trip threshold |
| retry_mode | input | 1 | Strap: 1 selects automatic retry, 0 selects latch-off |
| gate_en | output | 1 | Gate drive enable |
| gate_pd | output | 1 | Fast gate pull-down strobe |
| fail_pulse | output | 1 | One-cycle pulse on each fault timeout |
| oc_off | output | 1 | Gate is held off because of an overcurrent fault |

## Verification
The bench builds the block with FILT_LEN=4 and EN_ACT_HIGH=0, so the inverted enable path and short glitch filtering are exercised. Timer thresholds 200 and 1300 with steps 5, 60, 2 and 100 give phase lengths of 275, 23 and 552 cycles. With these values a full insertion, a timed fault, a retry cool-down and a latch-off release all fit into a few thousand cycles. Random bursts and glitches are drawn just below the fault and filter limits, and directed cases sit exactly on them.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_INIT_UP = 3'd1,
    ST_INIT_DN = 3'd2,
    ST_IDLE    = 3'd3,
    ST_ON      = 3'd4,
    ST_LATCH   = 3'd5,
    ST_COOL    = 3'd6
  } hsw_state_e;

  typedef enum logic [1:0] {
    RAMP_UP_INIT  = 2'd0,
    RAMP_UP_FAULT = 2'd1,
    RAMP_DN_FAST  = 2'd2,
    RAMP_DN_COOL  = 2'd3
  } ramp_cmd_e;

endpackage

// File: rtl/hsw_en_filt.sv
module hsw_en_filt #(
  parameter int FILT_LEN    = 16,
  parameter bit EN_ACT_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_pin,
  output logic en_ok
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic          act;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          filt_q, filt_d;
  logic          ce;

  generate
    if (EN_ACT_HIGH) begin : g_pol_high
      assign act = en_pin;
    end else begin : g_pol_low
      assign act = ~en_pin;
    end
  endgenerate

  always_comb begin
    cnt_d  = cnt_q;
    filt_d = filt_q;
    if (act != filt_q) begin
      if (cnt_q == LAST) begin
        filt_d = act;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
    end
  end

  assign ce = (cnt_d != cnt_q) || (filt_d != filt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (ce) begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end

  assign en_ok = filt_q;

endmodule

// File: rtl/hsw_ramp.sv
module hsw_ramp
  import hsw_pkg::*;
#(
  parameter int TMR_W      = 12,
  parameter int THR_HI     = 1300,
  parameter int THR_LO     = 200,
  parameter int RATE_INIT  = 5,
  parameter int RATE_FAULT = 60,
  parameter int RATE_COOL  = 2,
  parameter int RATE_DISCH = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ramp_cmd_e        cmd,
  output logic [TMR_W-1:0] tmr_val,
  output logic             at_hi,
  output logic             at_lo
);
  localparam logic [TMR_W-1:0] HI_V    = TMR_W'(THR_HI);
  localparam logic [TMR_W-1:0] LO_V    = TMR_W'(THR_LO);
  localparam logic [TMR_W-1:0] S_INIT  = TMR_W'(RATE_INIT);
  localparam logic [TMR_W-1:0] S_FAULT = TMR_W'(RATE_FAULT);
  localparam logic [TMR_W-1:0] S_COOL  = TMR_W'(RATE_COOL);
  localparam logic [TMR_W-1:0] S_DISCH = TMR_W'(RATE_DISCH);

  logic [TMR_W-1:0] val_q, val_d, step;
  logic [TMR_W:0]   up_sum;
  logic             going_up, ce;

  always_comb begin
    case (cmd)
      RAMP_UP_INIT:  step = S_INIT;
      RAMP_UP_FAULT: step = S_FAULT;
      RAMP_DN_COOL:  step = S_COOL;
      default:       step = S_DISCH;
    endcase
    going_up = (cmd == RAMP_UP_INIT) || (cmd == RAMP_UP_FAULT);
    up_sum   = {1'b0, val_q} + {1'b0, step};
    if (going_up) begin
      val_d = (up_sum >= {1'b0, HI_V}) ? HI_V : up_sum[TMR_W-1:0];
    end else begin
      val_d = (val_q < step) ? '0 : (val_q - step);
    end
  end

  assign ce = (val_d != val_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (ce) begin
      val_q <= val_d;
    end
  end

  assign tmr_val = val_q;
  assign at_hi   = (val_q >= HI_V);
  assign at_lo   = (val_q <= LO_V);

endmodule

// File: rtl/hsw_ctrl.sv
module hsw_ctrl
  import hsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       en_ok,
  input  logic       sw_off,
  input  logic       oc_flag,
  input  logic       retry_mode,
  input  logic       at_hi,
  input  logic       at_lo,
  output hsw_state_e state,
  output ramp_cmd_e  cmd,
  output logic       fail_pulse
);
  hsw_state_e state_q, state_d;
  logic       fail_q, fail_d;
  logic       run_ok;

  assign run_ok = en_ok && !sw_off;

  always_comb begin
    state_d = state_q;
    fail_d  = 1'b0;
    if (!supply_ok) begin
      state_d = ST_RESET;
    end else begin
      case (state_q)
        ST_RESET:   state_d = ST_INIT_UP;
        ST_INIT_UP: if (at_hi) state_d = ST_INIT_DN;
        ST_INIT_DN: if (at_lo) state_d = ST_IDLE;
        ST_IDLE:    if (run_ok) state_d = ST_ON;
        ST_ON: begin
          if (!run_ok) begin
            state_d = ST_IDLE;
          end else if (oc_flag && at_hi) begin
            fail_d  = 1'b1;
            state_d = retry_mode ? ST_COOL : ST_LATCH;
          end
        end
        ST_LATCH:   if (!en_ok) state_d = ST_IDLE;
        ST_COOL:    if (at_lo || !en_ok) state_d = ST_IDLE;
        default:    state_d = ST_RESET;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_INIT_UP: cmd = RAMP_UP_INIT;
      ST_ON:      cmd = oc_flag ? RAMP_UP_FAULT : RAMP_DN_FAST;
      ST_COOL:    cmd = RAMP_DN_COOL;
      default:    cmd = RAMP_DN_FAST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RESET;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fail_q  <= fail_d;
    end
  end

  assign state      = state_q;
  assign fail_pulse = fail_q;

endmodule

// File: rtl/hsw_seq.sv
module hsw_seq
  import hsw_pkg::*;
#(
  parameter int TMR_W       = 12,
  parameter int THR_HI      = 1300,
  parameter int THR_LO      = 200,
  parameter int RATE_INIT   = 5,
  parameter int RATE_FAULT  = 60,
  parameter int RATE_COOL   = 2,
  parameter int RATE_DISCH  = 100,
  parameter int FILT_LEN    = 16,
  parameter bit EN_ACT_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic en_pin,
  input  logic sw_off,
  input  logic oc_flag,
  input  logic fast_trip,
  input  logic retry_mode,
  output logic gate_en,
  output logic gate_pd,
  output logic fail_pulse,
  output logic oc_off
);
  logic             en_ok;
  logic [TMR_W-1:0] tmr_val;
  logic             at_hi, at_lo;
  hsw_state_e       state;
  ramp_cmd_e        cmd;

  hsw_en_filt #(
    .FILT_LEN   (FILT_LEN),
    .EN_ACT_HIGH(EN_ACT_HIGH)
  ) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .en_pin(en_pin),
    .en_ok (en_ok)
  );

  hsw_ramp #(
    .TMR_W     (TMR_W),
    .THR_HI    (THR_HI),
    .THR_LO    (THR_LO),
    .RATE_INIT (RATE_INIT),
    .RATE_FAULT(RATE_FAULT),
    .RATE_COOL (RATE_COOL),
    .RATE_DISCH(RATE_DISCH)
  ) u_ramp (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd),
    .tmr_val(tmr_val),
    .at_hi  (at_hi),
    .at_lo  (at_lo)
  );

  hsw_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .en_ok     (en_ok),
    .sw_off    (sw_off),
    .oc_flag   (oc_flag),
    .retry_mode(retry_mode),
    .at_hi     (at_hi),
    .at_lo     (at_lo),
    .state     (state),
    .cmd       (cmd),
    .fail_pulse(fail_pulse)
  );

  assign gate_en = (state == ST_ON);
  assign gate_pd = fast_trip && gate_en;
  assign oc_off  = (state == ST_LATCH) || (state == ST_COOL);

endmodule

// File: rtl/hsw_seq_chk.sv
module hsw_seq_chk #(
  parameter int TMR_W  = 12,
  parameter int THR_HI = 1300
) (
  input logic             clk,
  input logic             rst_n,
  input logic             supply_ok,
  input logic             sw_off,
  input logic             oc_flag,
  input logic             fast_trip,
  input logic             en_ok,
  input logic             gate_en,
  input logic             gate_pd,
  input logic             fail_pulse,
  input logic             oc_off,
  input logic [TMR_W-1:0] tmr_val
);
  assert_supply_low_gate_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !gate_en);

  assert_rise_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> $past(en_ok));

  assert_fail_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fail_pulse |=> !fail_pulse);

  assert_fail_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fail_pulse |-> (!gate_en && $past(oc_flag)));

  assert_oc_off_gate_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oc_off |-> !gate_en);

  assert_pd_needs_trip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gate_pd |-> fast_trip);

  assert_sw_off_gate_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_off |=> !gate_en);

  assert_timer_capped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_val <= TMR_W'(THR_HI));

endmodule

bind hsw_seq hsw_seq_chk #(
  .TMR_W (TMR_W),
  .THR_HI(THR_HI)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .supply_ok (supply_ok),
  .sw_off    (sw_off),
  .oc_flag   (oc_flag),
  .fast_trip (fast_trip),
  .en_ok     (en_ok),
  .gate_en   (gate_en),
  .gate_pd   (gate_pd),
  .fail_pulse(fail_pulse),
  .oc_off    (oc_off),
  .tmr_val   (tmr_val)
);

// File: tb/hsw_seq_test.sv
module hsw_seq_test;
  localparam int TW   = 12;
  localparam int HI   = 1300;
  localparam int LO   = 200;
  localparam int RI   = 5;
  localparam int RF   = 60;
  localparam int RC   = 2;
  localparam int RD   = 100;
  localparam int FILT = 4;

  logic clk, rst_n, supply_ok, en_pin, sw_off, oc_flag, fast_trip, retry_mode;
  logic gate_en, gate_pd, fail_pulse, oc_off;

  int checks = 0;
  int errors = 0;
  int fail_seen = 0;
  int cyc = 0;

  hsw_seq #(
    .TMR_W(TW), .THR_HI(HI), .THR_LO(LO), .RATE_INIT(RI), .RATE_FAULT(RF),
    .RATE_COOL(RC), .RATE_DISCH(RD), .FILT_LEN(FILT), .EN_ACT_HIGH(1'b0)
  ) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en_pin(en_pin),
    .sw_off(sw_off), .oc_flag(oc_flag), .fast_trip(fast_trip),
    .retry_mode(retry_mode), .gate_en(gate_en), .gate_pd(gate_pd),
    .fail_pulse(fail_pulse), .oc_off(oc_off)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int init_cycles();
    return 1 + cdiv(HI, RI) + 1 + cdiv(HI - LO, RD) + 2;
  endfunction
  function automatic int fault_cycles();
    return cdiv(HI, RF) + 1;
  endfunction
  function automatic int cool_cycles();
    return cdiv(HI - LO, RC) + 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_gate(input logic val, input int maxc, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (gate_en !== val && n < maxc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && fail_pulse === 1'b1) fail_seen++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, f0, k;
    bit stayed;
    void'($urandom(32'd2024));
    rst_n = 1'b0; supply_ok = 1'b0; en_pin = 1'b0; sw_off = 1'b0;
    oc_flag = 1'b0; fast_trip = 1'b0; retry_mode = 1'b1;
    idle(3);
    chk(gate_en === 1'b0 && gate_pd === 1'b0 && fail_pulse === 1'b0 && oc_off === 1'b0,
        "R1 reset outputs", int'(gate_en), 0);
    rst_n = 1'b1;
    idle(10);
    chk(gate_en === 1'b0, "R1 supply low keeps gate off", int'(gate_en), 0);

    // R2 and R11: power-up with active-low enable held low
    supply_ok = 1'b1;
    wait_gate(1'b1, 2000, n);
    chk(n == init_cycles(), "R2 initial cycle length", n, init_cycles());
    chk(gate_en === 1'b1, "R11 low level on en_pin enables", int'(gate_en), 1);
    idle(20);

    // R8 fast trip
    fast_trip = 1'b1;
    #1;
    chk(gate_pd === 1'b1, "R8 pull-down same cycle", int'(gate_pd), 1);
    @(negedge clk);
    fast_trip = 1'b0;
    #1;
    chk(gate_en === 1'b1 && gate_pd === 1'b0, "R8 gate unchanged by trip", int'(gate_en), 1);

    // R4 random sub-timeout bursts
    for (int r = 0; r < 8; r++) begin
      idle(20);
      f0 = fail_seen;
      k = int'($urandom_range(1, fault_cycles() - 2));
      oc_flag = 1'b1;
      idle(k);
      oc_flag = 1'b0;
      idle(20);
      chk(gate_en === 1'b1 && fail_seen == f0, "R4 short burst ignored", int'(gate_en), 1);
    end
    // R4 directed: longest burst that still ends below the threshold
    f0 = fail_seen;
    oc_flag = 1'b1;
    idle(fault_cycles() - 1);
    oc_flag = 1'b0;
    idle(20);
    chk(gate_en === 1'b1 && fail_seen == f0, "R4 burst at limit", fail_seen - f0, 0);

    // R10 random enable glitches
    for (int r = 0; r < 6; r++) begin
      stayed = 1'b1;
      k = int'($urandom_range(1, FILT - 1));
      en_pin = 1'b1;
      for (int i = 0; i < k; i++) begin
        @(negedge clk);
        if (gate_en !== 1'b1) stayed = 1'b0;
      end
      en_pin = 1'b0;
      for (int i = 0; i < FILT + 2; i++) begin
        @(negedge clk);
        if (gate_en !== 1'b1) stayed = 1'b0;
      end
      chk(stayed, "R10 glitch ignored", int'(stayed), 1);
    end

    // R5 and R7: fault with retry
    idle(20);
    f0 = fail_seen;
    oc_flag = 1'b1;
    wait_gate(1'b0, 200, n);
    chk(n == fault_cycles(), "R5 fault timeout length", n, fault_cycles());
    chk(fail_pulse === 1'b1, "R5 fail pulse with gate off", int'(fail_pulse), 1);
    chk(oc_off === 1'b1, "R7 oc_off during cool-down", int'(oc_off), 1);
    oc_flag = 1'b0;
    wait_gate(1'b1, 3000, n);
    chk(n == cool_cycles(), "R7 cool-down length", n, cool_cycles());
    chk(fail_seen - f0 == 1 && oc_off === 1'b0, "R5 single fail pulse", fail_seen - f0, 1);

    // R6 latch-off
    retry_mode = 1'b0;
    idle(20);
    oc_flag = 1'b1;
    wait_gate(1'b0, 200, n);
    chk(n == fault_cycles(), "R5 fault timeout latch mode", n, fault_cycles());
    oc_flag = 1'b0;
    idle(cool_cycles() + 100);
    chk(gate_en === 1'b0 && oc_off === 1'b1, "R6 latched off", int'(gate_en), 0);
    en_pin = 1'b1;
    idle(FILT + 3);
    chk(gate_en === 1'b0 && oc_off === 1'b0, "R6 release clears latch", int'(oc_off), 0);
    en_pin = 1'b0;
    wait_gate(1'b1, 50, n);
    chk(n == FILT + 1, "R6 reapply enable turns on", n, FILT + 1);

    // R9 software off and enable release
    idle(10);
    sw_off = 1'b1;
    @(negedge clk);
    chk(gate_en === 1'b0, "R9 sw_off next edge", int'(gate_en), 0);
    idle(5);
    sw_off = 1'b0;
    @(negedge clk);
    chk(gate_en === 1'b1, "R9 sw_off cleared", int'(gate_en), 1);
    en_pin = 1'b1;
    wait_gate(1'b0, 50, n);
    chk(n == FILT + 1, "R9 enable release latency", n, FILT + 1);
    en_pin = 1'b0;
    wait_gate(1'b1, 50, n);
    chk(n == FILT + 1, "R11 enable reapplied low", n, FILT + 1);

    // R12 supply drop, R3 enable off through the initial cycle
    idle(10);
    supply_ok = 1'b0;
    en_pin = 1'b1;
    @(negedge clk);
    chk(gate_en === 1'b0, "R12 supply drop next edge", int'(gate_en), 0);
    supply_ok = 1'b1;
    idle(init_cycles() + 20);
    chk(gate_en === 1'b0, "R3 enable off keeps gate off", int'(gate_en), 0);
    en_pin = 1'b0;
    wait_gate(1'b1, 50, n);
    chk(n == FILT + 1, "R3 late enable latency", n, FILT + 1);

    // R12 full restart after a one-cycle supply drop
    idle(10);
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    wait_gate(1'b1, 2000, n);
    chk(n == init_cycles(), "R12 restart repeats initial cycle", n, init_cycles());

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule